// File: doc/BRIEF.md
# I2C Slave with Byte Register Bank and Identification Channel

This block is an I2C slave for a chip that already has a fast system clock. It answers one fixed 7-bit device address. Behind that address sit eight byte-wide registers and a read-only channel that streams a fixed identification string. A master selects a location by sending a sub-address byte after a write address. It then writes consecutive bytes, or it reads consecutive bytes after a repeated start or a later read transfer. The register contents are also presented on a flat parallel bus, so neighbouring logic can use them as configuration.

The serial clock and data lines are oversampled through two-flop synchronizers, and start, stop and clock edges are found on the synchronized copies. The data line is only ever pulled low, through an active-high output enable. The design never drives the line high and never stretches the clock. It therefore works for standard-mode traffic (SCL up to 100 kHz, low phase of at least 4.7 µs, high phase of at least 4 µs) whenever each SCL phase spans several system clocks.

Top module: `i2c_regbank`

## Requirements
- R1: A falling SDA while SCL is high (start) begins reception of an address byte from any state. A rising SDA while SCL is high (stop) returns the slave to idle. In both cases `sda_oe` is low on the following clock.
- R2: Each byte takes nine SCL clocks. Eight data bits travel MSB first, sampled on SCL rising edges, and the ninth clock carries the acknowledge: low means ACK and high means NACK.
- R3: The first byte after a start is {address[6:0], direction}, where direction 1 means read. Only address 7'h6B (bytes 0xD6 for write and 0xD7 for read) is ACKed. Any other address gets no ACK, and later bytes are ignored (not ACKed, no register change) until the next start or stop.
- R4: In a write transfer, the byte after the address is the sub-address and is ACKed. Each later byte is ACKed and stored at the current location, which then advances. In register space the index advances from 7 back to 0.
- R5: A non-zero sub-address s selects register s mod 8 (its low three bits), so sub-address 8 selects register 0.
- R6: Sub-address 0 selects the identification channel. Reads return the ASCII string "RBK1" one character per byte, starting at "R", and wrap from "1" back to "R".
- R7: Data bytes written while sub-address 0 is selected are ACKed and discarded; `reg_out` does not change.
- R8: A read transfer starts at the location set by the most recent write transfer that carried a sub-address and no data byte. A repeated start keeps that location, and later writes that carry data do not move it.
- R9: During a read, the slave sends one byte per nine clocks and advances after each. A master ACK makes it send the next byte. A master NACK ends the transfer, and SDA stays released until the next start.
- R10: `sda_oe` changes only on the clock after a synchronized SCL falling edge and stays constant while SCL is high.
- R11: Register i appears on `reg_out[8*i+7:8*i]`. At most one register changes per clock, and only on the clock after a synchronized SCL falling edge.
- R12: After reset, `sda_oe` is low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_out | output | 64 | Parallel copy of the eight registers, register 0 in the low byte |

## Verification
The bench builds the block with its default parameters: eight registers, the four-character identification string and device address 7'h6B. It drives SCL with phases of only a dozen system clocks, so every device address in both directions can be swept within the run. A bench model of the open-drain line lets it see every acknowledge. Writes are swept through all sub-addresses 1 to 8. Bursts cross the 7-to-0 boundary, and reads run through all eight registers and past the end of the identification string, with every expected byte computed from the sub-address arithmetic.

// File: rtl/i2c_regbank_pkg.sv
// Shared types for the I2C register-bank slave.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package i2c_regbank_pkg;

    // Protocol sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } state_t;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        K_ADDR,
        K_SUB,
        K_DATA
    } kind_t;

    // Synchronized line levels and the events derived from them.
    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

endpackage

// File: rtl/i2c_regbank_sync.sv
// Synchronizes SCL and SDA and reports SCL edges plus start and stop events.
// Assumes: both lines idle high; each SCL phase lasts several clk periods.
module i2c_regbank_sync
    import i2c_regbank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;

    // Shift both lines through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    // Decode events from the current and previous synchronized samples.
    always_comb begin
        ev.scl   = scl_q[STAGES-1];
        ev.sda   = sda_q[STAGES-1];
        ev.rise  = scl_q[STAGES-1] & ~scl_q[STAGES];
        ev.fall  = ~scl_q[STAGES-1] & scl_q[STAGES];
        ev.start = scl_q[STAGES-1] & scl_q[STAGES] & sda_q[STAGES] & ~sda_q[STAGES-1];
        ev.stop  = scl_q[STAGES-1] & scl_q[STAGES] & ~sda_q[STAGES] & sda_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_regbank_store.sv
// Byte register array with one write port, plus the constant identification string.
// Assumes: rpos is always below ID_LEN; the first string character sits in the top byte.
module i2c_regbank_store #(
    parameter int                  NUM_REGS = 8,
    parameter int                  ID_LEN   = 4,
    parameter logic [8*ID_LEN-1:0] ID_STR   = "RBK1",
    localparam int                 IDX_W    = $clog2(NUM_REGS),
    localparam int                 POS_W    = $clog2(ID_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      widx,
    input  logic [7:0]            wdata,
    input  logic                  sel_id,
    input  logic [IDX_W-1:0]      ridx,
    input  logic [POS_W-1:0]      rpos,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    logic [7:0] regs [NUM_REGS];

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[widx] <= wdata;
        end
    end

    // Present the array as a flat bus for the host logic.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    // Select the byte for the next transmit: string character or register.
    always_comb begin
        if (sel_id) rdata = ID_STR[8*(ID_LEN-1-int'(rpos)) +: 8];
        else        rdata = regs[ridx];
    end

endmodule

// File: rtl/i2c_regbank_fsm.sv
// Byte-level I2C slave sequencer: address match, sub-address, write, read, acknowledge.
// Assumes: events come from i2c_regbank_sync; NUM_REGS is a power of two.
module i2c_regbank_fsm
    import i2c_regbank_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6B,
    parameter int         NUM_REGS = 8,
    parameter int         ID_LEN   = 4,
    localparam int        IDX_W    = $clog2(NUM_REGS),
    localparam int        POS_W    = $clog2(ID_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_ev_t         ev,
    input  logic [7:0]       rdata,
    output logic             we,
    output logic [IDX_W-1:0] widx,
    output logic [7:0]       wdata,
    output logic             sel_id,
    output logic [IDX_W-1:0] ridx,
    output logic [POS_W-1:0] rpos,
    output logic             sda_oe
);

    state_t           state;
    kind_t            kind;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic             rd, oe, macked;
    logic             wr_act, sub_got, data_seen;
    logic             cur_id, base_id;
    logic [IDX_W-1:0] cur_idx, base_idx;
    logic [POS_W-1:0] cur_pos;
    logic [POS_W-1:0] nxt_pos;
    logic             byte_done;

    // Next string position with wrap, and the end-of-byte condition.
    always_comb begin
        nxt_pos   = (cur_pos == POS_W'(ID_LEN-1)) ? '0 : cur_pos + 1'b1;
        byte_done = ev.fall && (bitcnt == 4'd8);
    end

    // Write strobe: a completed data byte aimed at register space.
    always_comb begin
        we     = (state == ST_RX) && (kind == K_DATA) && byte_done && !cur_id;
        widx   = cur_idx;
        wdata  = shreg;
        sel_id = cur_id;
        ridx   = cur_idx;
        rpos   = cur_pos;
        sda_oe = oe;
    end

    // Protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= K_ADDR;
            bitcnt    <= '0;
            shreg     <= '0;
            rd        <= 1'b0;
            oe        <= 1'b0;
            macked    <= 1'b0;
            wr_act    <= 1'b0;
            sub_got   <= 1'b0;
            data_seen <= 1'b0;
            cur_id    <= 1'b0;
            cur_idx   <= '0;
            cur_pos   <= '0;
            base_id   <= 1'b0;
            base_idx  <= '0;
        end else if (ev.start || ev.stop) begin
            if (wr_act && sub_got && !data_seen) begin
                base_id  <= cur_id;
                base_idx <= cur_idx;
            end
            wr_act    <= 1'b0;
            sub_got   <= 1'b0;
            data_seen <= 1'b0;
            rd        <= 1'b0;
            oe        <= 1'b0;
            bitcnt    <= '0;
            shreg     <= '0;
            kind      <= K_ADDR;
            state     <= ev.start ? ST_RX : ST_IDLE;
        end else begin
            case (state)
                ST_RX: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        case (kind)
                            K_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rd     <= shreg[0];
                                    wr_act <= !shreg[0];
                                    oe     <= 1'b1;
                                    state  <= ST_ACK;
                                    if (shreg[0]) begin
                                        cur_id  <= base_id;
                                        cur_idx <= base_idx;
                                        cur_pos <= '0;
                                    end
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            K_SUB: begin
                                cur_id  <= (shreg == 8'd0);
                                cur_idx <= shreg[IDX_W-1:0];
                                cur_pos <= '0;
                                sub_got <= 1'b1;
                                oe      <= 1'b1;
                                state   <= ST_ACK;
                            end
                            default: begin
                                if (cur_id) cur_pos <= nxt_pos;
                                else        cur_idx <= cur_idx + 1'b1;
                                data_seen <= 1'b1;
                                oe        <= 1'b1;
                                state     <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        if (rd) begin
                            oe     <= ~rdata[7];
                            shreg  <= {rdata[6:0], 1'b0};
                            bitcnt <= 4'd1;
                            state  <= ST_TX;
                        end else begin
                            oe     <= 1'b0;
                            bitcnt <= '0;
                            kind   <= (kind == K_ADDR) ? K_SUB : K_DATA;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 4'd8) begin
                            oe    <= 1'b0;
                            state <= ST_MACK;
                            if (cur_id) cur_pos <= nxt_pos;
                            else        cur_idx <= cur_idx + 1'b1;
                        end else begin
                            oe     <= ~shreg[7];
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        macked <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (macked) begin
                            oe     <= ~rdata[7];
                            shreg  <= {rdata[6:0], 1'b0};
                            bitcnt <= 4'd1;
                            state  <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_regbank.sv
// Top of the I2C register-bank slave: synchronizer, sequencer and storage.
// Assumes: the pad turns sda_oe into an open-drain pull-down; clk is much faster than SCL.
module i2c_regbank
    import i2c_regbank_pkg::*;
#(
    parameter logic [6:0]          DEV_ADDR    = 7'h6B,
    parameter int                  NUM_REGS    = 8,
    parameter int                  ID_LEN      = 4,
    parameter logic [8*ID_LEN-1:0] ID_STR      = "RBK1",
    parameter int                  SYNC_STAGES = 2,
    localparam int                 IDX_W       = $clog2(NUM_REGS),
    localparam int                 POS_W       = $clog2(ID_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_out
);

    line_ev_t         ev;
    logic             we, sel_id;
    logic [IDX_W-1:0] widx, ridx;
    logic [POS_W-1:0] rpos;
    logic [7:0]       wdata, rdata;

    i2c_regbank_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_regbank_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .ID_LEN   (ID_LEN)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .rdata  (rdata),
        .we     (we),
        .widx   (widx),
        .wdata  (wdata),
        .sel_id (sel_id),
        .ridx   (ridx),
        .rpos   (rpos),
        .sda_oe (sda_oe)
    );

    i2c_regbank_store #(
        .NUM_REGS (NUM_REGS),
        .ID_LEN   (ID_LEN),
        .ID_STR   (ID_STR)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .widx      (widx),
        .wdata     (wdata),
        .sel_id    (sel_id),
        .ridx      (ridx),
        .rpos      (rpos),
        .rdata     (rdata),
        .regs_flat (reg_out)
    );

endmodule

// File: rtl/i2c_regbank_chk.sv
// Protocol checker for i2c_regbank, attached with bind.
// Assumes: the bus master obeys I2C framing (no stop while the slave holds an ACK low).
module i2c_regbank_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_lvl,
    input logic                  scl_fall,
    input logic                  start_ev,
    input logic                  stop_ev,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] reg_out
);

    logic [NUM_REGS*8-1:0] prev_regs;
    logic [NUM_REGS-1:0]   chg;

    // Remember last cycle's register bus.
    always_ff @(posedge clk) prev_regs <= reg_out;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
        assign chg[g] = reg_out[g*8 +: 8] != prev_regs[g*8 +: 8];
    end

    // R1: release after start.
    a_r1_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);

    // R1: release after stop.
    a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R10: output enable stays put through the SCL high phase.
    a_r10_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R10: output enable moves only right after an SCL falling edge or a start/stop.
    a_r10_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)));

    // R11: at most one register changes per clock.
    a_r11_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg));

    // R11: register updates follow an SCL falling edge.
    a_r11_write_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |-> $past(scl_fall));

endmodule

bind i2c_regbank i2c_regbank_chk #(
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (ev.scl),
    .scl_fall (ev.fall),
    .start_ev (ev.start),
    .stop_ev  (ev.stop),
    .sda_oe   (sda_oe),
    .reg_out  (reg_out)
);

// File: tb/i2c_regbank_tb.sv
// Self-checking bench: bit-level I2C master model with an open-drain line.
module i2c_regbank_tb;

    localparam int          NREG = 8;
    localparam int          IDL  = 4;
    localparam logic [31:0] IDS  = "RBK1";
    localparam logic [6:0]  DEV  = 7'h6B;
    localparam int          Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] reg_out;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regbank #(
        .DEV_ADDR (DEV),
        .NUM_REGS (NREG),
        .ID_LEN   (IDL),
        .ID_STR   (IDS)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .reg_out (reg_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    int hi_moves = 0;
    bit done = 1'b0;
    logic [7:0] m [NREG];
    logic ack;
    logic [7:0] rb;
    logic prev_oe = 1'b0;

    // R10 monitor: count enable changes while the master holds SCL high.
    always @(negedge clk) begin
        if (rst_n && scl && (sda_oe !== prev_oe)) hi_moves++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i_start();
        sda_m = 1'b1; scl = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic i_stop();
        scl = 1'b0; sda_m = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl = 1'b1; wq(2*Q);
            scl = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic rbyte(input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl = 1'b1; wq(Q);
            rb[i] = sda_line; wq(Q);
            scl = 1'b0; wq(Q);
        end
        sda_m = ~give_ack; wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [63:0] packm();
        logic [63:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m[i];
        return v;
    endfunction

    function automatic logic [7:0] idch(input int k);
        return IDS[8*(IDL-1-(k % IDL)) +: 8];
    endfunction

    task automatic set_sub(input logic [7:0] s);
        i_start(); wbyte({DEV, 1'b0}); wbyte(s);
        chk(ack === 1'b1, "R4 sub-address ack", {63'd0, ack}, 64'd1);
        i_stop();
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) m[i] = 8'h00;
        wq(10);
        rst_n = 1'b1;
        wq(4);
        // R12: reset state.
        chk(sda_oe === 1'b0, "R12 oe after reset", {63'd0, sda_oe}, 64'd0);
        chk(reg_out === 64'd0, "R12 regs after reset", reg_out, 64'd0);

        // R3: sweep every address in both directions.
        for (int a = 0; a < 128; a++) begin
            for (int d = 0; d < 2; d++) begin
                i_start();
                wbyte({a[6:0], d[0]});
                chk(ack === (a == int'(DEV)), "R3 address ack", {63'd0, ack}, {63'd0, a == int'(DEV)});
                if (a != int'(DEV) && d == 0) begin
                    wbyte(8'h5A);
                    chk(ack === 1'b0, "R3 ignored after mismatch", {63'd0, ack}, 64'd0);
                    chk(reg_out === packm(), "R3 no write after mismatch", reg_out, packm());
                end
                if (a == int'(DEV) && d == 1) rbyte(1'b0);
                i_stop();
                chk(sda_oe === 1'b0, "R1 released after stop", {63'd0, sda_oe}, 64'd0);
            end
        end

        // R5 / R2: single writes to every sub-address 1..8.
        for (int s = 1; s <= 8; s++) begin
            logic [7:0] v;
            v = 8'(s * 37 + 5);
            i_start(); wbyte({DEV, 1'b0}); wbyte(8'(s)); wbyte(v);
            chk(ack === 1'b1, "R2 data ack", {63'd0, ack}, 64'd1);
            i_stop();
            m[s % 8] = v;
            chk(reg_out === packm(), "R5 fold sub-address", reg_out, packm());
        end

        // R4: burst write crossing index 7 -> 0.
        i_start(); wbyte({DEV, 1'b0}); wbyte(8'd6);
        for (int k = 0; k < 3; k++) begin
            wbyte(8'hC0 + 8'(k));
            m[(6 + k) % 8] = 8'hC0 + 8'(k);
        end
        i_stop();
        chk(reg_out === packm(), "R4 burst wrap", reg_out, packm());

        // R9: read all registers from index 3, NACK ends it.
        set_sub(8'd3);
        i_start(); wbyte({DEV, 1'b1});
        for (int k = 0; k < 8; k++) begin
            rbyte(k != 7);
            chk(rb === m[(3 + k) % 8], "R9 read stream", {56'd0, rb}, {56'd0, m[(3 + k) % 8]});
        end
        wq(2 * Q);
        chk(sda_oe === 1'b0, "R9 released after NACK", {63'd0, sda_oe}, 64'd0);
        i_stop();

        // R8: repeated start keeps the location just set.
        i_start(); wbyte({DEV, 1'b0}); wbyte(8'd5);
        i_start(); wbyte({DEV, 1'b1});
        rbyte(1'b1);
        chk(rb === m[5], "R8 repeated start read", {56'd0, rb}, {56'd0, m[5]});
        rbyte(1'b0);
        chk(rb === m[6], "R8 repeated start second", {56'd0, rb}, {56'd0, m[6]});
        i_stop();

        // R8: a write with data does not move the read start.
        set_sub(8'd2);
        i_start(); wbyte({DEV, 1'b0}); wbyte(8'd7); wbyte(8'h11); i_stop();
        m[7] = 8'h11;
        i_start(); wbyte({DEV, 1'b1}); rbyte(1'b0); i_stop();
        chk(rb === m[2], "R8 start from sub-only write", {56'd0, rb}, {56'd0, m[2]});

        // R6: identification channel with wrap.
        set_sub(8'd0);
        i_start(); wbyte({DEV, 1'b1});
        for (int k = 0; k < IDL + 2; k++) begin
            rbyte(k != IDL + 1);
            chk(rb === idch(k), "R6 id string", {56'd0, rb}, {56'd0, idch(k)});
        end
        i_stop();

        // R7: writes to the identification channel are acked and dropped.
        i_start(); wbyte({DEV, 1'b0}); wbyte(8'd0); wbyte(8'h77);
        chk(ack === 1'b1, "R7 id write ack", {63'd0, ack}, 64'd1);
        i_stop();
        chk(reg_out === packm(), "R7 id write discarded", reg_out, packm());

        // R10: nothing moved during SCL high phases.
        chk(hi_moves == 0, "R10 oe stable while SCL high", 64'(hi_moves), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule